// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block feeds an external chain of serial-in/parallel-out shift registers that light up to 24 LEDs, grouped as three 8-bit groups that can each be switched in or out of the chain. A host writes a 24-bit shadow word that gives the default value of every output. Some low bit fields can be handed to hardware instead. A two-bit line-status source can own bits 0–1. Four PHY LED buses of three bits each can own bits 2–4, 5–7, 8–10 and 11–13. Each field has a per-bit ownership mask.

The merged word is sent out serially on a data line and a shift clock, and a store strobe then latches the register outputs. When no bit is hardware-owned, each shadow write starts exactly one transfer. When any bit is hardware-owned, software writes no longer start transfers. Instead an internal timer refreshes the chain at a selectable rate of 4, 8 or 10 Hz. The capture edge of the shift clock is selectable. The hardware inputs are sampled once, at the start of each frame.

Top module: `led_shift_ctrl`

## Requirements
- R1: Transmitted bit i equals the hardware value where that bit's ownership mask is set, and the shadow bit otherwise. Ownership fields sit at fixed positions: line-status at bits 0–1, PHY n (n=0..3) at bits 2+3n to 4+3n. Bits 14–23 always come from the shadow word.
- R2: With all ownership masks zero, each `shadow_we` pulse starts exactly one transfer, and no transfer happens without one.
- R3: With any ownership bit set, `shadow_we` starts no transfer, and transfers repeat every CLK_HZ/4 cycles for `rate_sel`=0, CLK_HZ/8 cycles for 1, and CLK_HZ/10 cycles for 2 or 3.
- R4: A frame carries only the enabled groups (`grp_en` bit g enables word bits 8g+7..8g), highest group first and most-significant bit first, 8 bits per enabled group.
- R5: Each bit lasts 2*HALF_DIV clock cycles. `sclk` idles at the inverse of `rise_edge`, and the capture edge falls mid-bit: rising when `rise_edge`=1, falling when 0. `sdata` only changes in the non-capture half.
- R6: One bit period after the last bit starts, `sstore` is high for exactly one system clock cycle, with `sclk` at its idle level.
- R7: Requests that arrive during a transfer are held and collapse into one further transfer that starts after the store strobe and uses the newest shadow value.
- R8: Line-status and PHY inputs are sampled on the cycle a transfer starts. Later changes do not alter that frame.
- R9: When `grp_en` is all zero, a request is discarded and no transfer, clocking or strobe happens.
- R10: After reset `sclk`=1, `sdata`=0, `sstore`=0, `busy`=0, and the shadow word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_in | input | 24 | Value written into the shadow word |
| shadow_we | input | 1 | One-cycle shadow write strobe |
| grp_en | input | 3 | Per-group enable of the shift chain |
| line_mask | input | 2 | Ownership mask for the line-status field |
| line_bits | input | 2 | Line-status LED values |
| phy_mask | input | 12 | Ownership masks, 3 bits per PHY, PHY0 lowest |
| phy_leds | input | 12 | PHY LED values, 3 bits per PHY, PHY0 lowest |
| rate_sel | input | 2 | Refresh rate: 0=4 Hz, 1=8 Hz, 2/3=10 Hz |
| rise_edge | input | 1 | 1: capture on rising shift-clock edge, 0: falling |
| sclk | output | 1 | Shift clock to the register chain |
| sdata | output | 1 | Serial data to the register chain |
| sstore | output | 1 | Store strobe latching the register outputs |
| busy | output | 1 | A frame is in progress |

## Verification
The bench rebuilds each frame from the capture edges of `sclk`. It compares the bits against a word merged from the masks, which catches a wrong field offset or a group sent in the wrong order. It changes PHY inputs right after a frame begins, so a design that fed live inputs into the shifter would show the new values mid-frame. It writes the shadow word several times during a transfer; a design that dropped held requests would send one frame too few, and one that queued every request would send one too many. It measures the spacing of store strobes in refresh mode, checks that shadow writes add no frame there, and checks that a request with no group enabled leaves the lines silent.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_STORE = 2'd2
  } seq_state_t;

  localparam logic [1:0] RATE_4HZ  = 2'd0;
  localparam logic [1:0] RATE_8HZ  = 2'd1;
  localparam logic [1:0] RATE_10HZ = 2'd2;
endpackage

// File: rtl/led_merge.sv
module led_merge #(
  parameter int WORD_W = 24,
  parameter int LINE_W = 2,
  parameter int PHY_N  = 4,
  parameter int PHY_W  = 3
) (
  input  logic [WORD_W-1:0]      shadow,
  input  logic [LINE_W-1:0]      line_mask,
  input  logic [LINE_W-1:0]      line_bits,
  input  logic [PHY_N*PHY_W-1:0] phy_mask,
  input  logic [PHY_N*PHY_W-1:0] phy_leds,
  output logic [WORD_W-1:0]      merged,
  output logic                   hw_owned
);
  localparam int HW_TOP = LINE_W + PHY_N*PHY_W;

  logic [WORD_W-1:0] own_mask;
  logic [WORD_W-1:0] hw_val;

  assign own_mask[LINE_W-1:0] = line_mask;
  assign hw_val[LINE_W-1:0]   = line_bits;

  for (genvar p = 0; p < PHY_N; p++) begin : g_phy
    assign own_mask[LINE_W + p*PHY_W +: PHY_W] = phy_mask[p*PHY_W +: PHY_W];
    assign hw_val[LINE_W + p*PHY_W +: PHY_W]   = phy_leds[p*PHY_W +: PHY_W];
  end

  if (HW_TOP < WORD_W) begin : g_upper
    assign own_mask[WORD_W-1:HW_TOP] = '0;
    assign hw_val[WORD_W-1:HW_TOP]   = '0;
  end

  assign merged   = (own_mask & hw_val) | (~own_mask & shadow);
  assign hw_owned = |own_mask;
endmodule

// File: rtl/led_frame_pack.sv
module led_frame_pack #(
  parameter int GROUP_W = 8,
  parameter int GROUP_N = 3,
  localparam int WORD_W = GROUP_W*GROUP_N,
  localparam int BW     = $clog2(WORD_W+1)
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [GROUP_N-1:0] grp_en,
  output logic [WORD_W-1:0]  packed_word,
  output logic [BW-1:0]      nbits
);
  always_comb begin
    int pos;
    packed_word = '0;
    nbits       = '0;
    pos         = WORD_W;
    for (int g = GROUP_N-1; g >= 0; g--) begin
      if (grp_en[g]) begin
        packed_word[pos-1 -: GROUP_W] = word[g*GROUP_W +: GROUP_W];
        pos   = pos - GROUP_W;
        nbits = nbits + BW'(GROUP_W);
      end
    end
  end
endmodule

// File: rtl/led_refresh_timer.sv
module led_refresh_timer
  import led_shift_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  localparam int LIM_4  = CLK_HZ / 4;
  localparam int LIM_8  = CLK_HZ / 8;
  localparam int LIM_10 = CLK_HZ / 10;
  localparam int CW     = $clog2(LIM_4 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    case (rate_sel)
      RATE_4HZ: lim_m1 = CW'(LIM_4 - 1);
      RATE_8HZ: lim_m1 = CW'(LIM_8 - 1);
      default:  lim_m1 = CW'(LIM_10 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim_m1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/led_shift_seq.sv
module led_shift_seq
  import led_shift_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int HALF_DIV = 2,
  localparam int BW = $clog2(WORD_W+1),
  localparam int HW = $clog2(HALF_DIV+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] frame,
  input  logic [BW-1:0]     nbits,
  input  logic              rise_edge,
  output logic              sclk,
  output logic              sdata,
  output logic              sstore,
  output logic              busy,
  output logic              edge_q
);
  seq_state_t        st;
  logic [WORD_W-1:0] sr;
  logic [BW-1:0]     left;
  logic [HW-1:0]     hcnt;
  logic              phase;

  assign busy = (st != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_IDLE;
      sr     <= '0;
      left   <= '0;
      hcnt   <= '0;
      phase  <= 1'b0;
      sclk   <= 1'b1;
      sdata  <= 1'b0;
      sstore <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      case (st)
        SEQ_IDLE: begin
          edge_q <= rise_edge;
          sclk   <= !rise_edge;
          if (start) begin
            sr    <= frame << 1;
            sdata <= frame[WORD_W-1];
            left  <= nbits;
            hcnt  <= '0;
            phase <= 1'b0;
            st    <= SEQ_SHIFT;
          end
        end
        SEQ_SHIFT: begin
          if (hcnt == HW'(HALF_DIV-1)) begin
            hcnt <= '0;
            if (!phase) begin
              phase <= 1'b1;
              sclk  <= edge_q;
            end else begin
              phase <= 1'b0;
              sclk  <= !edge_q;
              if (left == BW'(1)) begin
                st     <= SEQ_STORE;
                sstore <= 1'b1;
              end else begin
                sdata <= sr[WORD_W-1];
                sr    <= sr << 1;
                left  <= left - 1'b1;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SEQ_STORE: begin
          sstore <= 1'b0;
          st     <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl #(
  parameter int GROUP_W  = 8,
  parameter int GROUP_N  = 3,
  parameter int LINE_W   = 2,
  parameter int PHY_N    = 4,
  parameter int PHY_W    = 3,
  parameter int HALF_DIV = 2,
  parameter int CLK_HZ   = 100_000_000,
  localparam int WORD_W  = GROUP_W*GROUP_N,
  localparam int PB_W    = PHY_N*PHY_W,
  localparam int BW      = $clog2(WORD_W+1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_W-1:0]  shadow_in,
  input  logic               shadow_we,
  input  logic [GROUP_N-1:0] grp_en,
  input  logic [LINE_W-1:0]  line_mask,
  input  logic [LINE_W-1:0]  line_bits,
  input  logic [PB_W-1:0]    phy_mask,
  input  logic [PB_W-1:0]    phy_leds,
  input  logic [1:0]         rate_sel,
  input  logic               rise_edge,
  output logic               sclk,
  output logic               sdata,
  output logic               sstore,
  output logic               busy
);
  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] packed_word;
  logic [BW-1:0]     nbits;
  logic              hw_owned;
  logic              tick;
  logic              pend;
  logic              new_req;
  logic              consume;
  logic              start;
  logic              edge_lat;

  always_ff @(posedge clk) begin
    if (rst)            shadow_q <= '0;
    else if (shadow_we) shadow_q <= shadow_in;
  end

  led_merge #(.WORD_W(WORD_W), .LINE_W(LINE_W), .PHY_N(PHY_N), .PHY_W(PHY_W)) u_merge (
    .shadow(shadow_q), .line_mask(line_mask), .line_bits(line_bits),
    .phy_mask(phy_mask), .phy_leds(phy_leds), .merged(merged), .hw_owned(hw_owned)
  );

  led_frame_pack #(.GROUP_W(GROUP_W), .GROUP_N(GROUP_N)) u_pack (
    .word(merged), .grp_en(grp_en), .packed_word(packed_word), .nbits(nbits)
  );

  led_refresh_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst(rst), .run(hw_owned), .rate_sel(rate_sel), .tick(tick)
  );

  assign new_req = (shadow_we && !hw_owned) || tick;
  assign consume = pend && !busy;
  assign start   = consume && (|grp_en);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend && !consume) || new_req;
  end

  led_shift_seq #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst(rst), .start(start), .frame(packed_word), .nbits(nbits),
    .rise_edge(rise_edge), .sclk(sclk), .sdata(sdata), .sstore(sstore),
    .busy(busy), .edge_q(edge_lat)
  );
endmodule

// File: rtl/led_shift_ctrl_chk.sv
module led_shift_ctrl_chk #(
  parameter int GROUP_N = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               sclk,
  input logic               sdata,
  input logic               sstore,
  input logic [GROUP_N-1:0] grp_en,
  input logic               edge_q
);
  a_r6_store_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sstore |=> !sstore);

  a_r6_store_in_frame: assert property (@(posedge clk) disable iff (rst)
    sstore |-> (busy && sclk != edge_q));

  a_r5_idle_clock_level: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk != edge_q));

  a_r5_data_in_setup_half: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !sstore && sdata != $past(sdata)) |-> (sclk != edge_q));

  a_r9_no_groups_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && grp_en == '0) |=> !busy);
endmodule

bind led_shift_ctrl led_shift_ctrl_chk #(.GROUP_N(GROUP_N)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sclk(sclk), .sdata(sdata),
  .sstore(sstore), .grp_en(grp_en), .edge_q(edge_lat)
);

// File: tb/tb_led_shift_ctrl.sv
`timescale 1ns/1ps
module tb_led_shift_ctrl;
  localparam int HALF  = 2;
  localparam int CLKHZ = 4000;

  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] shadow_in = '0;
  logic        shadow_we = 0;
  logic [2:0]  grp_en = 3'b111;
  logic [1:0]  line_mask = '0, line_bits = '0;
  logic [11:0] phy_mask = '0, phy_leds = '0;
  logic [1:0]  rate_sel = 2'd2;
  logic        rise_edge = 0;
  logic        sclk, sdata, sstore, busy;

  int errors = 0, checks = 0;
  int cyc = 0;

  led_shift_ctrl #(.HALF_DIV(HALF), .CLK_HZ(CLKHZ)) dut (
    .clk(clk), .rst(rst), .shadow_in(shadow_in), .shadow_we(shadow_we),
    .grp_en(grp_en), .line_mask(line_mask), .line_bits(line_bits),
    .phy_mask(phy_mask), .phy_leds(phy_leds), .rate_sel(rate_sel),
    .rise_edge(rise_edge), .sclk(sclk), .sdata(sdata), .sstore(sstore), .busy(busy)
  );

  always #5 clk = ~clk;

  // monitor: rebuilds frames from capture edges
  logic [23:0] cap = '0, last_word = '0;
  int ncap = 0, last_n = 0, frames = 0, busy_rises = 0;
  int last_cap_t = 0, spacing_err = 0, width_err = 0, idle_err = 0;
  int last_store_t = 0, prev_store_t = 0;
  logic prev_sclk = 1, prev_sstore = 0, prev_busy = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (busy && !prev_busy) busy_rises++;
      if (sclk != prev_sclk && sclk == rise_edge && busy) begin
        if (ncap > 0 && (cyc - last_cap_t) != 2*HALF) spacing_err++;
        cap = {cap[22:0], sdata};
        ncap++;
        last_cap_t = cyc;
      end
      if (sstore) begin
        if (prev_sstore) width_err++;
        else begin
          if (sclk != !rise_edge) idle_err++;
          last_word = cap; last_n = ncap; cap = '0; ncap = 0;
          prev_store_t = last_store_t; last_store_t = cyc;
          frames++;
        end
      end
    end
    prev_sclk = sclk; prev_sstore = sstore; prev_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] merge_ref(input logic [23:0] sh, input logic [1:0] lm,
      input logic [1:0] lb, input logic [11:0] pm, input logic [11:0] pl);
    logic [23:0] r;
    r = sh;
    for (int i = 0; i < 2; i++) if (lm[i]) r[i] = lb[i];
    for (int i = 0; i < 12; i++) if (pm[i]) r[2+i] = pl[i];
    return r;
  endfunction

  function automatic logic [23:0] pack_ref(input logic [23:0] w, input logic [2:0] en);
    logic [23:0] v;
    v = '0;
    for (int g = 2; g >= 0; g--) if (en[g]) v = (v << 8) | 24'(w[g*8 +: 8]);
    return v;
  endfunction

  function automatic int nbits_ref(input logic [2:0] en);
    return 8 * $countones(en);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frames(input int target, input int limit);
    int k;
    k = 0;
    while (frames < target && k < limit) begin @(negedge clk); k++; end
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    tick(2);
  endtask

  task automatic write_shadow(input logic [23:0] v);
    shadow_in = v; shadow_we = 1; tick(1); shadow_we = 0;
  endtask

  task automatic t_reset();
    chk(sclk == 1'b1, "R10 sclk", sclk, 1);
    chk(sdata == 1'b0, "R10 sdata", sdata, 0);
    chk(sstore == 1'b0, "R10 sstore", sstore, 0);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    write_shadow(24'h0);
    // shadow was zero: an all-group frame must be all zero
    wait_frames(1, 500);
    chk(last_word == 24'h0, "R10 shadow zero", last_word, 0);
  endtask

  task automatic t_sw_update(input logic [23:0] v, input logic [2:0] en, input logic re);
    int f0, se, we;
    grp_en = en; rise_edge = re; tick(3);
    f0 = frames; se = spacing_err; we = width_err;
    write_shadow(v);
    wait_frames(f0 + 1, 500);
    chk(frames == f0 + 1, "R2 one frame per write", frames - f0, 1);
    chk(last_n == nbits_ref(en), "R4 bit count", last_n, nbits_ref(en));
    chk(last_word == pack_ref(v, en), "R4 frame order", last_word, pack_ref(v, en));
    chk(spacing_err == se, "R5 bit period", spacing_err - se, 0);
    chk(width_err == we && idle_err == 0, "R6 store strobe", width_err - we, 0);
    tick(1200);
    chk(frames == f0 + 1, "R2 no spontaneous frame", frames - f0, 1);
  endtask

  task automatic t_auto_merge();
    logic [23:0] e;
    int f0;
    wait_idle();
    grp_en = 3'b111; rise_edge = 0; rate_sel = 2'd2;
    write_shadow(24'hA5C3_F0);
    line_mask = 2'b01; line_bits = 2'b10;
    phy_mask = 12'b101_000_110_011; phy_leds = 12'b010_111_001_100;
    f0 = frames;
    wait_frames(f0 + 3, 2000);
    e = merge_ref(24'hA5C3_F0, line_mask, line_bits, phy_mask, phy_leds);
    chk(last_word == e, "R1 merged word", last_word, e);
    chk(last_store_t - prev_store_t == CLKHZ/10, "R3 10Hz period", last_store_t - prev_store_t, CLKHZ/10);
    // shadow writes in auto mode must not add frames
    f0 = frames;
    tick(50); write_shadow(24'h00FFFF); tick(50); write_shadow(24'h123456);
    tick(400 - 101);
    chk(frames - f0 <= 1, "R3 write ignored in auto", frames - f0, 1);
    rate_sel = 2'd0;
    f0 = frames;
    wait_frames(f0 + 3, 4000);
    chk(last_store_t - prev_store_t == CLKHZ/4, "R3 4Hz period", last_store_t - prev_store_t, CLKHZ/4);
    rate_sel = 2'd1;
    f0 = frames;
    wait_frames(f0 + 3, 3000);
    chk(last_store_t - prev_store_t == CLKHZ/8, "R3 8Hz period", last_store_t - prev_store_t, CLKHZ/8);
    e = merge_ref(24'h123456, line_mask, line_bits, phy_mask, phy_leds);
    chk(last_word == e, "R1 shadow bits outside owned", last_word, e);
  endtask

  task automatic t_sample();
    logic [23:0] e_old, e_new;
    int f0, k;
    rate_sel = 2'd2; phy_mask = 12'hFFF; line_mask = 2'b11;
    phy_leds = 12'h5A3; line_bits = 2'b01;
    wait_idle();
    k = 0;
    while (!busy && k < 1000) begin @(negedge clk); k++; end
    while (busy && k < 2000) begin @(negedge clk); k++; end
    k = 0;
    while (!busy && k < 1000) begin @(negedge clk); k++; end
    f0 = frames;
    e_old = merge_ref(24'h123456, 2'b11, 2'b01, 12'hFFF, 12'h5A3);
    phy_leds = 12'hA5C; line_bits = 2'b10;
    e_new = merge_ref(24'h123456, 2'b11, 2'b10, 12'hFFF, 12'hA5C);
    wait_frames(f0 + 1, 500);
    chk(last_word == e_old, "R8 inputs sampled at start", last_word, e_old);
    wait_frames(f0 + 2, 1000);
    chk(last_word == e_new, "R8 next frame new inputs", last_word, e_new);
  endtask

  task automatic t_pending();
    int f0, k;
    line_mask = '0; phy_mask = '0; grp_en = 3'b111; rise_edge = 1;
    tick(500); wait_idle(); tick(5);
    f0 = frames;
    write_shadow(24'h111111);
    k = 0;
    while (!busy && k < 100) begin @(negedge clk); k++; end
    tick(10); write_shadow(24'h222222);
    tick(10); write_shadow(24'h333333);
    wait_frames(f0 + 2, 1000);
    tick(300);
    chk(frames == f0 + 2, "R7 held requests collapse", frames - f0, 2);
    chk(last_word == 24'h333333, "R7 newest shadow sent", last_word, 24'h333333);
  endtask

  task automatic t_no_groups();
    int f0, b0;
    wait_idle();
    grp_en = 3'b000; tick(2);
    f0 = frames; b0 = busy_rises;
    write_shadow(24'h0F0F0F);
    tick(300);
    chk(frames == f0, "R9 no strobe", frames - f0, 0);
    chk(busy_rises == b0, "R9 no transfer", busy_rises - b0, 0);
    chk(sclk == !rise_edge, "R9 clock idle", sclk, !rise_edge);
    grp_en = 3'b001; tick(2);
    write_shadow(24'h0000C3);
    wait_frames(f0 + 1, 500);
    chk(last_word == 24'h0000C3 && last_n == 8, "R4 single low group", last_word, 24'h0000C3);
  endtask

  initial begin
    tick(4); rst = 0; tick(2);
    t_reset();
    t_sw_update(24'hC3_5A_81, 3'b111, 1'b0);
    t_sw_update(24'h9E_77_1B, 3'b101, 1'b1);
    t_sw_update(24'h42_D6_E9, 3'b010, 1'b0);
    t_auto_merge();
    t_sample();
    t_pending();
    t_no_groups();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule